// File: doc/BRIEF.md
# Multi-lane transmit frame packer

This block sits between a client packet source and a wide transmit datapath. On its input it takes one 64-bit beat per cycle under a valid/ready handshake. Each beat carries a start flag, an end flag, a 3-bit count of unused bytes and an error flag. On its output it presents `LANES` 64-bit lanes every cycle. Each lane has its own start, end, empty-count, idle and error indications. The downstream consumer takes the presented word at every clock edge where its request input is high. Between such edges the word is held.

Beats are placed into lanes in arrival order. The first beat in time goes to the most significant lane. A frame may begin in any lane, including the lane right after another frame's end within the same word. Lanes that hold no beat are marked idle and carry zeros. Frames of eight bytes or fewer cannot be handled downstream, so they are removed here. A frame is held back one beat at its start until its length is known. A frame that ends on its first beat is discarded without trace.

The default is two lanes (128 bits). Four lanes (256 bits) is the other intended setting.

Top module: `tx_lane_packer`

## Requirements
- R1: After reset every output lane is idle, and all data, start, end, empty and error outputs are zero.
- R2: Beats reach the output in input order. Within one output word, earlier beats occupy higher lane indices. Filled lanes are contiguous from lane `LANES-1` downward, with idle lanes only below them. A frame may start in the lane directly after another frame's end in the same word.
- R3: Lane i occupies `m_data[64*i+63:64*i]` and bit i of each flag vector (bits `3*i+2:3*i` of `m_empty`). The first beat of a word therefore lands in the top 64 bits, and bit 0 of the start vector refers to `m_data[63:0]`.
- R4: A start flag appears only on a lane carrying the first beat of a frame, never on an idle lane.
- R5: The lane carrying a frame's last beat shows that beat's empty count. Every other lane shows empty zero. Empty values supplied on beats without the end flag are ignored.
- R6: A frame whose first beat also has the end flag (eight bytes or fewer) never appears on the output. Every frame of two or more beats appears complete.
- R7: The error flag is set on a lane exactly when that lane carries a frame's last beat and that beat had its error input set. Error inputs on other beats are ignored.
- R8: An idle lane carries zero data and zero start, end, empty and error flags.
- R9: The output word changes only at clock edges where `m_req` is high. At an edge with `m_req` low it is held unchanged.
- R10: While `m_req` stays low the internal storage fills and `s_ready` drops. No accepted beat is lost or duplicated across such stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with `s_valid` |
| s_data | input | 64 | Input beat, big-endian bytes |
| s_sop | input | 1 | Beat is the first of a frame |
| s_eop | input | 1 | Beat is the last of a frame |
| s_empty | input | 3 | Unused bytes in the last beat |
| s_err | input | 1 | Error mark, meaningful on the last beat |
| m_req | input | 1 | Downstream takes the presented word at this edge |
| m_data | output | 64*LANES | Lane data, lane LANES-1 first in time |
| m_sop | output | LANES | Per-lane frame start |
| m_eop | output | LANES | Per-lane frame end |
| m_empty | output | 3*LANES | Per-lane empty byte count |
| m_idle | output | LANES | Per-lane no-data flag |
| m_err | output | LANES | Per-lane error on frame end |

## Verification
The checks assume the source sends well-formed frames. The start flag comes only on a frame's first beat, the end flag only on its last, and frames never interleave. A beat is held unchanged while it waits for `s_ready`. The bench builds every frame in a loop that sets the start flag on beat zero and the end flag on the final beat. It holds each beat until the handshake completes, and it varies frame length, empty count and error only through loop indices. The request input is driven from a cycle-count schedule. That schedule mixes continuous, alternating and sparse requests with long stretches of none, so that the lane position of frame starts and the buffer-full condition are both reached.

// File: rtl/tx_pack_pkg.sv
package tx_pack_pkg;

    localparam int WORD_W  = 64;
    localparam int EMPTY_W = 3;

    typedef struct packed {
        logic [WORD_W-1:0]  data;
        logic               sop;
        logic               eop;
        logic [EMPTY_W-1:0] empty;
        logic               err;
    } beat_t;

endpackage

// File: rtl/tx_short_filter.sv
// Two-entry buffer that withholds a frame's first beat until a second beat
// proves the frame is longer than one word; single-beat frames are dropped.
module tx_short_filter
    import tx_pack_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  i_valid,
    output logic  i_ready,
    input  beat_t i_beat,
    output logic  o_valid,
    input  logic  o_ready,
    output beat_t o_beat
);

    typedef struct packed {
        beat_t [1:0] slot;
        logic  [1:0] vld;
        logic  [1:0] conf;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic    pop;
    logic    push;

    assign i_ready = ~st_q.vld[1];
    assign o_valid = st_q.vld[0] & st_q.conf[0];
    assign o_beat  = st_q.slot[0];

    always_comb begin
        st_d = st_q;
        pop  = st_q.vld[0] & st_q.conf[0] & o_ready;
        push = i_valid & i_ready & ~(i_beat.sop & i_beat.eop);

        if (pop) begin
            st_d.slot[0] = st_q.slot[1];
            st_d.slot[1] = '0;
            st_d.vld     = {1'b0, st_q.vld[1]};
            st_d.conf    = {1'b0, st_q.conf[1]};
        end

        if (push) begin
            // a continuation beat proves every held beat belongs to a long frame
            if (!i_beat.sop) begin
                st_d.conf = st_d.vld;
            end
            if (!st_d.vld[0]) begin
                st_d.slot[0] = i_beat;
                st_d.vld[0]  = 1'b1;
                st_d.conf[0] = ~i_beat.sop;
            end else begin
                st_d.slot[1] = i_beat;
                st_d.vld[1]  = 1'b1;
                st_d.conf[1] = ~i_beat.sop;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tx_lane_fill.sv
// Collects beats into a wide word, top lane first, and hands the word to the
// output register at every edge where the consumer requests.
module tx_lane_fill
    import tx_pack_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    output logic              i_ready,
    input  beat_t             i_beat,
    input  logic              req,
    output beat_t [LANES-1:0] o_lane,
    output logic  [LANES-1:0] o_idle
);

    localparam int             CW   = $clog2(LANES + 1);
    localparam logic [CW-1:0]  FULL = CW'(LANES);

    typedef struct packed {
        beat_t [LANES-1:0] bld;
        logic  [CW-1:0]    cnt;
        beat_t [LANES-1:0] out;
        logic  [LANES-1:0] idle;
    } fill_st_t;

    fill_st_t      st_d, st_q;
    beat_t         clean;
    logic [CW-1:0] slot;

    assign i_ready = (st_q.cnt != FULL) | req;
    assign o_lane  = st_q.out;
    assign o_idle  = st_q.idle;

    always_comb begin
        clean       = i_beat;
        clean.err   = i_beat.err & i_beat.eop;
        clean.empty = i_beat.eop ? i_beat.empty : '0;
    end

    always_comb begin
        st_d = st_q;
        slot = st_q.cnt;

        if (req) begin
            st_d.out = st_q.bld;
            for (int i = 0; i < LANES; i++) begin
                st_d.idle[i] = (CW'(LANES - 1 - i) >= st_q.cnt);
            end
            st_d.bld = '0;
            slot     = '0;
        end

        if (i_valid && i_ready) begin
            for (int i = 0; i < LANES; i++) begin
                if (CW'(LANES - 1 - i) == slot) begin
                    st_d.bld[i] = clean;
                end
            end
            slot = slot + 1'b1;
        end

        st_d.cnt = slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.idle <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tx_lane_packer.sv
module tx_lane_packer
    import tx_pack_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [WORD_W-1:0]    s_data,
    input  logic                 s_sop,
    input  logic                 s_eop,
    input  logic [EMPTY_W-1:0]   s_empty,
    input  logic                 s_err,
    input  logic                 m_req,
    output logic [LANES*64-1:0]  m_data,
    output logic [LANES-1:0]     m_sop,
    output logic [LANES-1:0]     m_eop,
    output logic [LANES*3-1:0]   m_empty,
    output logic [LANES-1:0]     m_idle,
    output logic [LANES-1:0]     m_err
);

    beat_t             in_beat;
    beat_t             flt_beat;
    logic              flt_valid;
    logic              fill_ready;
    beat_t [LANES-1:0] lane;

    assign in_beat.data  = s_data;
    assign in_beat.sop   = s_sop;
    assign in_beat.eop   = s_eop;
    assign in_beat.empty = s_empty;
    assign in_beat.err   = s_err;

    tx_short_filter filt_i (
        .clk     (clk),
        .rst     (rst),
        .i_valid (s_valid),
        .i_ready (s_ready),
        .i_beat  (in_beat),
        .o_valid (flt_valid),
        .o_ready (fill_ready),
        .o_beat  (flt_beat)
    );

    tx_lane_fill #(.LANES(LANES)) fill_i (
        .clk     (clk),
        .rst     (rst),
        .i_valid (flt_valid),
        .i_ready (fill_ready),
        .i_beat  (flt_beat),
        .req     (m_req),
        .o_lane  (lane),
        .o_idle  (m_idle)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign m_data[g*WORD_W +: WORD_W]    = lane[g].data;
        assign m_sop[g]                      = lane[g].sop;
        assign m_eop[g]                      = lane[g].eop;
        assign m_empty[g*EMPTY_W +: EMPTY_W] = lane[g].empty;
        assign m_err[g]                      = lane[g].err;
    end

endmodule

// File: rtl/tx_lane_packer_chk.sv
module tx_lane_packer_chk #(
    parameter int LANES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                m_req,
    input logic [LANES*64-1:0] m_data,
    input logic [LANES-1:0]    m_sop,
    input logic [LANES-1:0]    m_eop,
    input logic [LANES*3-1:0]  m_empty,
    input logic [LANES-1:0]    m_idle,
    input logic [LANES-1:0]    m_err
);

    assert_hold_when_no_req_R9: assert property (@(posedge clk) disable iff (rst)
        !m_req |=> ($stable(m_data) && $stable(m_idle) && $stable(m_sop) &&
                    $stable(m_eop) && $stable(m_empty) && $stable(m_err)));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        assert_idle_lane_clean_R8: assert property (@(posedge clk) disable iff (rst)
            m_idle[g] |-> (m_data[g*64 +: 64] == '0 && !m_sop[g] && !m_eop[g] &&
                           m_empty[g*3 +: 3] == '0 && !m_err[g]));

        assert_sop_on_live_lane_R4: assert property (@(posedge clk) disable iff (rst)
            m_sop[g] |-> !m_idle[g]);

        assert_empty_only_at_end_R5: assert property (@(posedge clk) disable iff (rst)
            (m_empty[g*3 +: 3] != '0) |-> m_eop[g]);

        assert_err_only_at_end_R7: assert property (@(posedge clk) disable iff (rst)
            m_err[g] |-> m_eop[g]);
    end

    for (genvar g = 1; g < LANES; g++) begin : g_fill
        assert_idle_below_idle_R2: assert property (@(posedge clk) disable iff (rst)
            m_idle[g] |-> m_idle[g-1]);
    end

endmodule

bind tx_lane_packer tx_lane_packer_chk #(.LANES(LANES)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .m_req   (m_req),
    .m_data  (m_data),
    .m_sop   (m_sop),
    .m_eop   (m_eop),
    .m_empty (m_empty),
    .m_idle  (m_idle),
    .m_err   (m_err)
);

// File: tb/tx_lane_packer_tb_top.sv
module tx_lane_packer_tb_top;

    localparam int LANES = 2;

    logic                clk = 1'b0;
    logic                rst;
    logic                s_valid;
    logic                s_ready;
    logic [63:0]         s_data;
    logic                s_sop;
    logic                s_eop;
    logic [2:0]          s_empty;
    logic                s_err;
    logic                m_req;
    logic [LANES*64-1:0] m_data;
    logic [LANES-1:0]    m_sop;
    logic [LANES-1:0]    m_eop;
    logic [LANES*3-1:0]  m_empty;
    logic [LANES-1:0]    m_idle;
    logic [LANES-1:0]    m_err;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [68:0] exp_q[$];
    bit          saw_stall = 0;
    int          n_frames_out = 0;
    int          n_long = 0;

    always #10 clk = ~clk;

    tx_lane_packer #(.LANES(LANES)) dut_i (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_sop(s_sop), .s_eop(s_eop), .s_empty(s_empty), .s_err(s_err),
        .m_req(m_req), .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop),
        .m_empty(m_empty), .m_idle(m_idle), .m_err(m_err)
    );

    task automatic check(input bit ok, input string rq, input logic [68:0] act,
                         input logic [68:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // one beat, held until the handshake completes
    task automatic send_beat(input logic [63:0] d, input logic sp, input logic ep,
                             input logic [2:0] em, input logic er);
        bit acc;
        @(negedge clk);
        s_valid = 1'b1; s_data = d; s_sop = sp; s_eop = ep; s_empty = em; s_err = er;
        forever begin
            acc = s_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
    endtask

    // stimulus: sweep frame length, empty count and error mark
    initial begin
        int fid;
        fid = 0;
        rst = 1'b1; s_valid = 1'b0; s_data = '0; s_sop = 1'b0; s_eop = 1'b0;
        s_empty = '0; s_err = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state seen at the ports
        check(m_idle == '1, "R1 idle", 69'(m_idle), 69'({LANES{1'b1}}));
        check(m_data == '0 && m_sop == '0 && m_eop == '0 && m_empty == '0 && m_err == '0,
              "R1 flags", 69'({m_sop, m_eop, m_err, m_empty}), 69'(0));
        for (int nb = 1; nb <= 5; nb++) begin
            for (int em = 0; em < 8; em++) begin
                for (int er = 0; er < 2; er++) begin
                    fid++;
                    for (int b = 0; b < nb; b++) begin
                        logic [63:0] d;
                        logic        sp, ep;
                        d  = {32'(fid) ^ 32'h5A00_0000, 16'(b), 16'hC0DE};
                        sp = (b == 0);
                        ep = (b == nb - 1);
                        if (nb >= 2)
                            exp_q.push_back({d, sp, ep, ep ? 3'(em) : 3'd0,
                                             ep & er[0]});
                        // junk empty on middle beats must be ignored (R5)
                        send_beat(d, sp, ep, ep ? 3'(em) : 3'(b + 1), er[0]);
                    end
                    if (nb >= 2) n_long++;
                    if (fid % 7 == 0) begin
                        @(negedge clk);
                        s_valid = 1'b0;
                        repeat (fid % 3) @(negedge clk);
                    end
                end
            end
        end
        @(negedge clk);
        s_valid = 1'b0;
        for (int w = 0; w < 3000 && exp_q.size() != 0; w++) @(negedge clk);
        repeat (10) @(negedge clk);
        // R6 R10: every long frame arrived, nothing extra or lost
        check(exp_q.size() == 0, "R6 R10 leftover beats", 69'(exp_q.size()), 69'(0));
        check(n_frames_out == n_long, "R6 frame count", 69'(n_frames_out), 69'(n_long));
        check(saw_stall, "R10 ready dropped under stall", 69'(saw_stall), 69'(1));
        finish_run();
    end

    // request schedule and output monitor
    initial begin
        int          cyc;
        bit          prev_req;
        logic [LANES*64-1:0] p_data;
        logic [LANES*12-1:0] p_flags;
        cyc = 0; prev_req = 1'b0; m_req = 1'b0;
        p_data = '0; p_flags = '0;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            int  ph;
            bit  below_idle;
            logic [LANES*12-1:0] flags;
            flags = {m_sop, m_eop, m_empty, m_idle, m_err, {LANES*3{1'b0}}};
            if (cyc > 0 && !prev_req) begin
                // R9: no request at the last edge, word unchanged
                check(m_data == p_data && flags == p_flags, "R9 hold",
                      69'(m_data ^ p_data), 69'(0));
            end
            ph = (cyc / 60) % 4;
            case (ph)
                0:       m_req = 1'b1;
                1:       m_req = (cyc % 2 == 0);
                2:       m_req = 1'b0;
                default: m_req = (cyc % 5 == 0);
            endcase
            if (!s_ready) saw_stall = 1'b1;
            if (m_req) begin
                below_idle = 1'b0;
                for (int i = LANES - 1; i >= 0; i--) begin
                    logic [68:0] act;
                    act = {m_data[i*64 +: 64], m_sop[i], m_eop[i], m_empty[i*3 +: 3], m_err[i]};
                    if (m_idle[i]) begin
                        below_idle = 1'b1;
                        // R8: idle lane carries nothing
                        check(act == '0, "R8 idle lane", act, 69'(0));
                    end else begin
                        // R2: no live lane below an idle one
                        check(!below_idle, "R2 contiguous fill", 69'(i), 69'(LANES - 1));
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R6 unexpected beat", act, 69'(0));
                        end else begin
                            logic [68:0] e;
                            e = exp_q.pop_front();
                            // R2 R3 R4 R5 R7: order, lane position and flags
                            check(act == e, "R2 R3 R4 R5 R7 lane beat", act, e);
                            if (e[4] && act == e) n_frames_out++;
                        end
                    end
                end
            end
            p_data  = m_data;
            p_flags = flags;
            prev_req = m_req;
            cyc++;
            @(negedge clk);
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        finish_run();
    end

endmodule